// File: doc/BRIEF.md
# Presettable Cascadable Down Counter

A small binary down counter, four bits wide by default, used for divide-by-N. One system clock runs the whole block. A slow count-clock input and an inhibit input are synchronized to that clock and their edges are found from the synchronized copies. Normally a rising count-clock edge takes one off the count. When the count clock is held high, a falling inhibit edge also takes one off, so inhibit can serve as a second count source. Holding inhibit high blocks all counting.

A synchronous preset-enable loads a parallel preset word and has priority over counting. A zero flag is raised while the count is all zeros and the cascade-feedback input is high. For a single stage, the zero flag is fed back to preset-enable with cascade feedback tied high. The counter then reloads N after each pass through zero, which gives one zero pulse every N count edges. Several stages can be chained through their cascade-feedback inputs with no extra gates.

Top module: `pdc_divider`

## Requirements
- R1: While rst_ni is low, count_o is 0. With cascade_fb_i high, zero_o is then 1.
- R2: A rising edge on cnt_clk_i while inhibit_i is low lowers count_o by one. count_o changes after the third rising system-clock edge that follows the input change (two synchronizer stages plus the count register).
- R3: A falling edge on inhibit_i while cnt_clk_i is high lowers count_o by one, with the same latency as R2.
- R4: While inhibit_i is high, rising edges on cnt_clk_i leave count_o unchanged. A falling edge of inhibit_i while cnt_clk_i is low leaves count_o unchanged.
- R5: Counting down from 0 wraps to all ones (15 at the default width).
- R6: When preset_en_i is high at a rising system-clock edge, count_o takes preset_val_i at that edge. Count edges are ignored while preset_en_i stays high.
- R7: zero_o is 1 exactly when count_o is 0 and cascade_fb_i is 1. It follows cascade_fb_i with no register in between.
- R8: When zero_o drives preset_en_i and the preset value is N, zero_o rises once for every N count edges.
- R9: A rising count-clock edge and a falling inhibit edge that are seen in the same system cycle give a single decrement.
- R10: A falling edge of cnt_clk_i leaves count_o unchanged. A rising edge of inhibit_i also leaves count_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_clk_i | input | 1 | Count clock, asynchronous, rising edge counts |
| inhibit_i | input | 1 | Blocks counting when high; its falling edge counts while cnt_clk_i is high |
| preset_en_i | input | 1 | Synchronous load of preset_val_i |
| preset_val_i | input | WIDTH | Preset word |
| cascade_fb_i | input | 1 | Qualifies the zero flag |
| count_o | output | WIDTH | Current count |
| zero_o | output | 1 | Count is zero and cascade feedback is high |

## Verification
The assertions assume that each level on cnt_clk_i and inhibit_i lasts at least one system cycle, so that the synchronizers see every edge. They also assume that preset_en_i and preset_val_i are stable around each system-clock edge. The bench changes every input on the falling system-clock edge. It holds each count-clock and inhibit level for three cycles or more, so no edge is lost or merged, except in the one case that tests a count-clock edge and an inhibit edge landing in the same cycle on purpose. In divide-by-N mode the preset-enable comes from zero_o, which is a combinational output; the bench compares it against its own model on every cycle.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int unsigned PDC_WIDTH       = 4;
  localparam int unsigned PDC_SYNC_STAGES = 2;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } pdc_edge_t;
endpackage

// File: rtl/pdc_sync_edge.sv
module pdc_sync_edge
  import pdc_pkg::*;
#(
  parameter int unsigned STAGES = PDC_SYNC_STAGES
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      async_i,
  output pdc_edge_t edge_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q[i] <= 1'b0;
        else         sr_q[i] <= async_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q[i] <= 1'b0;
        else         sr_q[i] <= sr_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sr_q[STAGES-1];

  assign edge_o.lvl  = sr_q[STAGES-1];
  assign edge_o.rise = sr_q[STAGES-1] & ~prev_q;
  assign edge_o.fall = ~sr_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pdc_step_ctrl.sv
module pdc_step_ctrl
  import pdc_pkg::*;
(
  input  pdc_edge_t ck_i,
  input  pdc_edge_t inh_i,
  output logic      step_o
);
  logic ck_step, inh_step;

  // normal path: count clock rises while not inhibited
  assign ck_step  = ck_i.rise & ~inh_i.lvl;
  // alternate path: inhibit falls while count clock is high
  assign inh_step = inh_i.fall & ck_i.lvl;
  assign step_o   = ck_step | inh_step;
endmodule

// File: rtl/pdc_count_core.sv
module pdc_count_core #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] count_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= cnt_q - ONE;

  assign count_o = cnt_q;
endmodule

// File: rtl/pdc_zero_dec.sv
module pdc_zero_dec #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             cascade_i,
  output logic             zero_o
);
  assign zero_o = ~(|count_i) & cascade_i;
endmodule

// File: rtl/pdc_divider.sv
module pdc_divider
  import pdc_pkg::*;
#(
  parameter int unsigned WIDTH       = PDC_WIDTH,
  parameter int unsigned SYNC_STAGES = PDC_SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_clk_i,
  input  logic             inhibit_i,
  input  logic             preset_en_i,
  input  logic [WIDTH-1:0] preset_val_i,
  input  logic             cascade_fb_i,
  output logic [WIDTH-1:0] count_o,
  output logic             zero_o
);
  pdc_edge_t ck_e, inh_e;
  logic      step;

  pdc_sync_edge #(.STAGES(SYNC_STAGES)) u_ck_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(cnt_clk_i), .edge_o(ck_e)
  );

  pdc_sync_edge #(.STAGES(SYNC_STAGES)) u_inh_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(inhibit_i), .edge_o(inh_e)
  );

  pdc_step_ctrl u_step (
    .ck_i(ck_e), .inh_i(inh_e), .step_o(step)
  );

  pdc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(preset_en_i),
    .load_val_i(preset_val_i), .step_i(step), .count_o(count_o)
  );

  pdc_zero_dec #(.WIDTH(WIDTH)) u_zero (
    .count_i(count_o), .cascade_i(cascade_fb_i), .zero_o(zero_o)
  );
endmodule

// File: rtl/pdc_divider_chk.sv
module pdc_divider_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_clk_i,
  input logic             inhibit_i,
  input logic             preset_en_i,
  input logic [WIDTH-1:0] preset_val_i,
  input logic             cascade_fb_i,
  input logic [WIDTH-1:0] count_o,
  input logic             zero_o
);
  // R6
  preset_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(preset_en_i) && $past(rst_ni)) |-> count_o == $past(preset_val_i));

  // R2 R5
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(preset_en_i) |->
      (count_o == $past(count_o) || count_o == WIDTH'($past(count_o) - 1'b1)));

  // R4
  inhibit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(inhibit_i, 3) && $past(inhibit_i, 4) && !$past(preset_en_i)) |->
      $stable(count_o));

  // R7
  cascade_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cascade_fb_i |-> !zero_o);

  // R7
  zero_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> count_o == '0);
endmodule

bind pdc_divider pdc_divider_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_clk_i(cnt_clk_i), .inhibit_i(inhibit_i),
  .preset_en_i(preset_en_i), .preset_val_i(preset_val_i),
  .cascade_fb_i(cascade_fb_i), .count_o(count_o), .zero_o(zero_o)
);

// File: tb/pdc_divider_tb_top.sv
module pdc_divider_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int MODV       = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ck = 1'b0, inh = 1'b0, pe_drv = 1'b0, cfb = 1'b1, loop_mode = 1'b0;
  logic [W-1:0] pv = '0;
  logic [W-1:0] count;
  logic         zero;
  logic         pe;

  int total = 0, bad = 0, cycles = 0, zero_rises = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pe = loop_mode ? zero : pe_drv;

  pdc_divider #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(ck), .inhibit_i(inh),
    .preset_en_i(pe), .preset_val_i(pv), .cascade_fb_i(cfb),
    .count_o(count), .zero_o(zero)
  );

  // behavioural reference: input history queues, integer count
  int   m_cnt = 0;
  bit   ck_h[$] = '{0, 0, 0};
  bit   ih_h[$] = '{0, 0, 0};
  int   m_zero;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      ck_h  = '{0, 0, 0};
      ih_h  = '{0, 0, 0};
    end else begin
      bit cs, cp, is, ip, do_step, do_load;
      cs = ck_h[1]; cp = ck_h[2];
      is = ih_h[1]; ip = ih_h[2];
      do_load = loop_mode ? (m_cnt == 0 && cfb) : pe_drv;
      do_step = (cs && !cp && !is) || (!is && ip && cs);
      if (do_load)      m_cnt = int'(pv);
      else if (do_step) m_cnt = (m_cnt + MODV - 1) % MODV;
      ck_h.push_front(ck); void'(ck_h.pop_back());
      ih_h.push_front(inh); void'(ih_h.pop_back());
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  logic zero_prev = 1'b0;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      m_zero = (m_cnt == 0 && cfb) ? 1 : 0;
      chk({cur_req, " count"}, int'(count), m_cnt);
      chk({cur_req, " zero"}, int'(zero), m_zero);
      if (zero && !zero_prev) zero_rises++;
    end
    zero_prev = zero;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ck(input int n);
    for (int i = 0; i < n; i++) begin
      ck = 1'b1; wait_n(3);
      ck = 1'b0; wait_n(3);
    end
  endtask

  initial begin
    wait_n(3);
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 zero", int'(zero), 1);
    rst_n = 1'b1;
    wait_n(2);

    cur_req = "R5";
    pulse_ck(1); wait_n(2);
    chk("R5 wrap", int'(count), MODV - 1);

    cur_req = "R2";
    ck = 1'b1; wait_n(2);
    chk("R2 not yet", int'(count), MODV - 1);
    wait_n(1);
    chk("R2 latency", int'(count), MODV - 2);
    ck = 1'b0; wait_n(3);
    pulse_ck(2); wait_n(2);
    chk("R2 pulses", int'(count), 12);

    cur_req = "R10";
    ck = 1'b1; wait_n(4);
    inh = 1'b1; wait_n(4);
    chk("R10 inhibit rise", int'(count), 11);

    cur_req = "R3";
    inh = 1'b0; wait_n(4);
    chk("R3 inhibit fall", int'(count), 10);

    cur_req = "R10";
    ck = 1'b0; wait_n(4);
    chk("R10 clock fall", int'(count), 10);

    cur_req = "R4";
    inh = 1'b1; wait_n(3);
    pulse_ck(3);
    chk("R4 blocked", int'(count), 10);
    inh = 1'b0; wait_n(4);
    chk("R4 fall with clock low", int'(count), 10);

    cur_req = "R9";
    inh = 1'b1; wait_n(4);
    ck = 1'b1; inh = 1'b0; wait_n(4);
    chk("R9 single step", int'(count), 9);
    ck = 1'b0; wait_n(3);

    cur_req = "R6";
    pv = 4'd6; pe_drv = 1'b1;
    wait_n(1);
    chk("R6 load", int'(count), 6);
    pulse_ck(1); wait_n(4);
    chk("R6 hold", int'(count), 6);
    pe_drv = 1'b0; wait_n(4);
    chk("R6 after release", int'(count), 6);

    cur_req = "R7";
    pv = 4'd0; pe_drv = 1'b1; wait_n(1);
    pe_drv = 1'b0; wait_n(1);
    chk("R7 zero high", int'(zero), 1);
    cfb = 1'b0; #1;
    chk("R7 gated", int'(zero), 0);
    wait_n(2);
    cfb = 1'b1; #1;
    chk("R7 ungated", int'(zero), 1);
    wait_n(2);

    cur_req = "R8";
    pv = 4'd5; loop_mode = 1'b1; wait_n(3);
    chk("R8 reload", int'(count), 5);
    zero_rises = 0;
    pulse_ck(15); wait_n(4);
    chk("R8 zero pulses", zero_rises, 3);
    chk("R8 final", int'(count), 5);
    loop_mode = 1'b0; wait_n(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule